// File: doc/BRIEF.md
# Bitstream Configuration Loader Bridge

This block sits between a host byte stream (valid/ready handshake, one byte per transfer) and two consumers: a user data port and the configuration port of a programmable target device. In data mode the host stream passes straight through to the user port with no added latency. In configuration mode the block treats the host stream as a bitstream. It first checks a 4-byte signature and then reads a 4-byte payload length. Only after both does it touch the target: it holds the program line low, waits for the target to signal readiness, and then clocks the payload into the target.

The configuration path is picked at elaboration. It is either 1-bit serial, where each byte is shifted out most significant bit first with a configuration clock at half the system clock, or 8-bit parallel, with one configuration clock pulse per byte. When the payload is done, the block keeps pulsing the configuration clock until the target raises its done flag or a pulse limit runs out. It then reports success or failure. On success it falls back to data mode by itself.

Two host strobes steer the mode. `enter_cfg` forces the wait-for-bitstream state from anywhere. `exit_cfg` forces data mode from anywhere, and it wins when both strobes arrive in the same cycle. After reset the block is waiting for a bitstream.

Top module: `cfg_loader_bridge`

## Requirements
- R1: After reset the block waits for a bitstream. `in_ready` is 1, `user_valid` stays 0 even when `in_valid` is 1, `prog_n` is 1, `cclk` is 0, and `cfg_ok`/`cfg_err` are 0.
- R2: A one-cycle `enter_cfg` pulse (without `exit_cfg`) moves the block from any state to the wait-for-bitstream state and clears `cfg_ok` and `cfg_err` on the next cycle.
- R3: The first four accepted bytes must equal `SIGNATURE` taken most significant byte first (default A5, C3, 5A, 96). On the first mismatching byte `cfg_err` is set and `prog_n` never goes low. Later bytes are accepted (`in_ready`=1) and dropped, with no `cclk` pulse and no `user_valid`, until a strobe arrives.
- R4: The four bytes after the signature form the payload length, most significant byte first. The cycle after the last length byte is accepted, `prog_n` goes low for exactly `PROG_CYCLES` cycles (default 16).
- R5: After the program pulse no `cclk` edge occurs until `init_n` is 1. If `init_n` stays 0 for `INIT_TIMEOUT` cycles, `cfg_err` is set. `cclk` is never high while `prog_n` is low.
- R6: With `SERIAL`=1 (default) each payload byte is shifted out most significant bit first on `cfg_d[0]`, one bit per `cclk` rising edge. `cclk` has a period of two system clocks, and `in_ready` is 0 while a byte is shifting.
- R7: When the accepted payload byte count equals the length, extra `cclk` pulses are issued. The cycle after `done` is seen high, `cfg_ok` is 1 and the block is in data mode.
- R8: If `done` stays low for `DONE_LIMIT` extra pulses (default 32), `cfg_err` is set and `cfg_ok` stays 0.
- R9: `exit_cfg` moves the block to data mode from any state on the next cycle, takes priority over `enter_cfg`, and leaves the flags unchanged.
- R10: In data mode `user_data` equals `in_data`, `user_valid` equals `in_valid` and `in_ready` equals `user_ready`, combinationally.
- R11: `user_valid` is 0 in every configuration state, so no bitstream byte reaches the user port.
- R12: `cfg_ok` and `cfg_err` are never 1 together, and each holds its value until the next `enter_cfg`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enter_cfg | input | 1 | Strobe: wait for a new bitstream |
| exit_cfg | input | 1 | Strobe: return to data mode |
| in_data | input | 8 | Host stream byte |
| in_valid | input | 1 | Host byte valid |
| in_ready | output | 1 | Block accepts host byte |
| user_data | output | 8 | Pass-through byte to user logic |
| user_valid | output | 1 | Pass-through byte valid |
| user_ready | input | 1 | User logic accepts byte |
| prog_n | output | 1 | Target program/reset line, active low |
| init_n | input | 1 | Target ready for data (high = ready) |
| done | input | 1 | Target configuration complete |
| cclk | output | 1 | Configuration clock to target |
| cfg_d | output | SERIAL?1:8 | Configuration data to target |
| cfg_ok | output | 1 | Last load succeeded |
| cfg_err | output | 1 | Last load failed |

## Verification
The checker watches these properties on every cycle:
- the program pulse width, and that `cclk` stays quiet while `prog_n` is low;
- that `in_ready` drops whenever `cclk` is high;
- that no user-port valid appears during a program pulse or a configuration clock;
- that the two flags are never set together;
- the effect of both strobes one cycle later.

Only the bench scenarios can show the rest:
- the bit order on the serial line and the payload length taken from the header;
- that a bad signature never pulses `prog_n`;
- the init timeout and the done-limit failure;
- the fall-back to pass-through after a good load.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

   typedef enum logic [2:0] {
      LD_PASS  = 3'd0,
      LD_SIG   = 3'd1,
      LD_LEN   = 3'd2,
      LD_PROG  = 3'd3,
      LD_INIT  = 3'd4,
      LD_SHIFT = 3'd5,
      LD_FLUSH = 3'd6,
      LD_FAIL  = 3'd7
   } ld_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cfg_timer.sv
module cfg_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] cnt
);

   if (W < 1) begin : g_bad_w
      $error("cfg_timer: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (en)
         cnt <= cnt + W'(1);
   end

endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
   parameter int DW = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          abort,
   input  logic          load,
   input  logic [7:0]    byte_in,
   output logic          busy,
   output logic          sclk,
   output logic [DW-1:0] dout
);

   localparam int NSTEP = 8 / DW;
   localparam int SW    = $clog2(NSTEP + 1);

   if (DW != 1 && DW != 8) begin : g_bad_dw
      $error("cfg_shifter: DW must be 1 or 8");
   end

   logic [7:0]    sh_q;
   logic [7:0]    sh_next;
   logic [SW-1:0] left_q;
   logic          phase_q;

   if (DW == 1) begin : g_serial
      assign sh_next = {sh_q[6:0], 1'b0};
   end else begin : g_parallel
      assign sh_next = sh_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         left_q  <= '0;
         phase_q <= 1'b0;
         busy    <= 1'b0;
      end else if (abort) begin
         left_q  <= '0;
         phase_q <= 1'b0;
         busy    <= 1'b0;
      end else if (load && !busy) begin
         sh_q    <= byte_in;
         left_q  <= SW'(NSTEP);
         phase_q <= 1'b0;
         busy    <= 1'b1;
      end else if (busy) begin
         if (!phase_q) begin
            phase_q <= 1'b1;
         end else begin
            phase_q <= 1'b0;
            sh_q    <= sh_next;
            left_q  <= left_q - SW'(1);
            if (left_q == SW'(1))
               busy <= 1'b0;
         end
      end
   end

   assign sclk = phase_q;
   assign dout = sh_q[7 -: DW];

endmodule

// File: rtl/cfg_loader_bridge.sv
module cfg_loader_bridge
   import cfg_loader_pkg::*;
#(
   parameter bit          SERIAL       = 1'b1,
   parameter logic [31:0] SIGNATURE    = 32'hA5C3_5A96,
   parameter int          PROG_CYCLES  = 16,
   parameter int          INIT_TIMEOUT = 64,
   parameter int          DONE_LIMIT   = 32,
   localparam int         DW           = SERIAL ? 1 : 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enter_cfg,
   input  logic          exit_cfg,
   input  logic [7:0]    in_data,
   input  logic          in_valid,
   output logic          in_ready,
   output logic [7:0]    user_data,
   output logic          user_valid,
   input  logic          user_ready,
   output logic          prog_n,
   input  logic          init_n,
   input  logic          done,
   output logic          cclk,
   output logic [DW-1:0] cfg_d,
   output logic          cfg_ok,
   output logic          cfg_err
);

   localparam int DONE_CYC = 2 * DONE_LIMIT;
   localparam int TMAX     = imax(imax(PROG_CYCLES, INIT_TIMEOUT), DONE_CYC);
   localparam int TW       = $clog2(TMAX + 1);
   localparam int LW       = 32;

   if (PROG_CYCLES < 1) begin : g_bad_prog
      $error("cfg_loader_bridge: PROG_CYCLES must be at least 1");
   end
   if (INIT_TIMEOUT < 1) begin : g_bad_init
      $error("cfg_loader_bridge: INIT_TIMEOUT must be at least 1");
   end
   if (DONE_LIMIT < 1) begin : g_bad_done
      $error("cfg_loader_bridge: DONE_LIMIT must be at least 1");
   end

   ld_state_e      st_q, st_nxt;
   logic [TW-1:0]  tmr;
   logic [LW-1:0]  bcnt;
   logic [LW-1:0]  len_q;
   logic           cnt_clr;
   logic           accept;
   logic           sh_busy, sh_clk, sh_load, sh_abort;
   logic           dclk_q;
   logic [1:0]     sig_idx;
   logic [7:0]     sig_byte;
   logic           hdr_last;

   // Signature byte expected at the current header position, MSB first
   assign sig_idx  = 2'd3 - bcnt[1:0];
   assign sig_byte = SIGNATURE[{sig_idx, 3'b000} +: 8];
   assign hdr_last = (bcnt[1:0] == 2'd3);

   // Ready selection per state
   always_comb begin
      unique case (st_q)
         LD_PASS:                in_ready = user_ready;
         LD_SIG, LD_LEN, LD_FAIL: in_ready = 1'b1;
         LD_SHIFT:               in_ready = !sh_busy && (bcnt != len_q);
         default:                in_ready = 1'b0;
      endcase
   end

   assign accept = in_valid && in_ready;

   // Next-state selection; strobes override, exit first
   always_comb begin
      st_nxt = st_q;
      unique case (st_q)
         LD_PASS: st_nxt = LD_PASS;
         LD_SIG: begin
            if (accept) begin
               if (in_data != sig_byte)
                  st_nxt = LD_FAIL;
               else if (hdr_last)
                  st_nxt = LD_LEN;
            end
         end
         LD_LEN: begin
            if (accept && hdr_last)
               st_nxt = LD_PROG;
         end
         LD_PROG: begin
            if (tmr == TW'(PROG_CYCLES - 1))
               st_nxt = LD_INIT;
         end
         LD_INIT: begin
            if (init_n)
               st_nxt = LD_SHIFT;
            else if (tmr == TW'(INIT_TIMEOUT - 1))
               st_nxt = LD_FAIL;
         end
         LD_SHIFT: begin
            if (!sh_busy && (bcnt == len_q))
               st_nxt = LD_FLUSH;
         end
         LD_FLUSH: begin
            if (done)
               st_nxt = LD_PASS;
            else if (tmr == TW'(DONE_CYC - 1))
               st_nxt = LD_FAIL;
         end
         LD_FAIL: st_nxt = LD_FAIL;
         default: st_nxt = LD_SIG;
      endcase
      if (exit_cfg)
         st_nxt = LD_PASS;
      else if (enter_cfg)
         st_nxt = LD_SIG;
   end

   assign cnt_clr = (st_nxt != st_q) || enter_cfg || exit_cfg;

   cfg_timer #(.W(TW)) i_cyc_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .en    (1'b1),
      .cnt   (tmr)
   );

   cfg_timer #(.W(LW)) i_byte_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .en    (accept),
      .cnt   (bcnt)
   );

   assign sh_load  = accept && (st_q == LD_SHIFT);
   assign sh_abort = (st_nxt != LD_SHIFT);

   cfg_shifter #(.DW(DW)) i_shifter (
      .clk     (clk),
      .rst_n   (rst_n),
      .abort   (sh_abort),
      .load    (sh_load),
      .byte_in (in_data),
      .busy    (sh_busy),
      .sclk    (sh_clk),
      .dout    (cfg_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= LD_SIG;
         len_q   <= '0;
         dclk_q  <= 1'b0;
         cfg_ok  <= 1'b0;
         cfg_err <= 1'b0;
      end else begin
         st_q <= st_nxt;
         if (st_q == LD_LEN && accept)
            len_q <= {len_q[LW-9:0], in_data};
         dclk_q <= (st_q == LD_FLUSH && st_nxt == LD_FLUSH) ? !dclk_q : 1'b0;
         if (enter_cfg && !exit_cfg) begin
            cfg_ok  <= 1'b0;
            cfg_err <= 1'b0;
         end else begin
            if (st_q != LD_FAIL && st_nxt == LD_FAIL)
               cfg_err <= 1'b1;
            if (st_q == LD_FLUSH && st_nxt == LD_PASS && !exit_cfg)
               cfg_ok <= 1'b1;
         end
      end
   end

   assign prog_n     = (st_q != LD_PROG);
   assign cclk       = sh_clk | dclk_q;
   assign user_data  = in_data;
   assign user_valid = (st_q == LD_PASS) && in_valid;

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
   parameter int PROG_CYCLES = 16
) (
   input logic clk,
   input logic rst_n,
   input logic enter_cfg,
   input logic exit_cfg,
   input logic in_ready,
   input logic user_valid,
   input logic prog_n,
   input logic cclk,
   input logic cfg_ok,
   input logic cfg_err
);

   int lowcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lowcnt <= 0;
      else
         lowcnt <= prog_n ? 0 : lowcnt + 1;
   end

   // R4: program pulse is exactly PROG_CYCLES long
   p_prog_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_n) |-> (lowcnt == PROG_CYCLES));

   // R4: program pulse never exceeds PROG_CYCLES
   p_prog_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_n |-> (lowcnt < PROG_CYCLES));

   // R5: no configuration clock while the target is held in program
   p_quiet_prog_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_n |-> !cclk);

   // R6: host stream stalled while a configuration clock is high
   p_stall_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cclk |-> !in_ready);

   // R11: nothing reaches the user port during configuration activity
   p_no_leak_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!prog_n || cclk) |-> !user_valid);

   // R12: success and failure flags exclusive
   p_flags_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_ok && cfg_err));

   // R2: enter strobe clears both flags
   p_enter_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (enter_cfg && !exit_cfg) |=> (!cfg_ok && !cfg_err));

   // R9: exit strobe leaves the target idle next cycle
   p_exit_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      exit_cfg |=> (prog_n && !cclk));

endmodule

bind cfg_loader_bridge cfg_loader_chk #(.PROG_CYCLES(PROG_CYCLES)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enter_cfg  (enter_cfg),
   .exit_cfg   (exit_cfg),
   .in_ready   (in_ready),
   .user_valid (user_valid),
   .prog_n     (prog_n),
   .cclk       (cclk),
   .cfg_ok     (cfg_ok),
   .cfg_err    (cfg_err)
);

// File: tb/test_cfg_loader_bridge.sv
`timescale 1ns/1ps
module test_cfg_loader_bridge;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enter_cfg = 1'b0, exit_cfg = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] user_data;
   logic       user_valid;
   logic       user_ready = 1'b0;
   logic       prog_n;
   logic       init_n = 1'b0;
   logic       done = 1'b0;
   logic       cclk;
   logic [0:0] cfg_d;
   logic       cfg_ok, cfg_err;

   int n_vec = 0, n_err = 0, cyc = 0;
   int pulses = 0, falls = 0;
   logic [15:0] cap = '0;

   always #2 clk = ~clk;

   cfg_loader_bridge i_cfg_loader_bridge (
      .clk(clk), .rst_n(rst_n), .enter_cfg(enter_cfg), .exit_cfg(exit_cfg),
      .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .user_data(user_data), .user_valid(user_valid), .user_ready(user_ready),
      .prog_n(prog_n), .init_n(init_n), .done(done), .cclk(cclk),
      .cfg_d(cfg_d), .cfg_ok(cfg_ok), .cfg_err(cfg_err)
   );

   always @(posedge cclk) begin
      cap    <= {cap[14:0], cfg_d[0]};
      pulses <= pulses + 1;
   end

   always @(negedge prog_n) falls <= falls + 1;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_err = n_err + 1;
         $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
         $finish;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec = n_vec + 1;
      if (act !== exp) begin
         n_err = n_err + 1;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      in_data  = b;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic header(input logic [31:0] len);
      send(8'hA5); send(8'hC3); send(8'h5A); send(8'h96);
      send(len[31:24]); send(len[23:16]); send(len[15:8]); send(len[7:0]);
   endtask

   task automatic strobe(input logic en, input logic ex);
      @(negedge clk);
      enter_cfg = en;
      exit_cfg  = ex;
      @(negedge clk);
      enter_cfg = 1'b0;
      exit_cfg  = 1'b0;
   endtask

   // {in_data, in_valid, user_ready, exp_user_valid, exp_in_ready}
   localparam int NV = 6;
   localparam logic [11:0] VEC [NV] = '{
      {8'h11, 1'b1, 1'b1, 1'b1, 1'b1},
      {8'h22, 1'b0, 1'b1, 1'b0, 1'b1},
      {8'h33, 1'b1, 1'b0, 1'b1, 1'b0},
      {8'hA5, 1'b1, 1'b1, 1'b1, 1'b1},
      {8'hFF, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h00, 1'b1, 1'b1, 1'b1, 1'b1}
   };

   initial begin
      int lowcnt, p0, f0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state waits for a bitstream
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'h55;
      #1;
      check("R1 in_ready", in_ready, 1);
      check("R1 user_valid", user_valid, 0);
      check("R1 prog_n", prog_n, 1);
      check("R1 cclk", cclk, 0);
      check("R1 flags", {cfg_ok, cfg_err}, 0);
      in_valid = 1'b0;

      // Good load: length 2, payload B4 3C
      header(32'd2);
      lowcnt = 0;
      while (!prog_n) begin
         lowcnt = lowcnt + 1;
         @(negedge clk);
      end
      check("R4 prog_n low cycles", lowcnt, 16);
      repeat (5) @(negedge clk);
      check("R5 no cclk before init_n", pulses, 0);
      init_n = 1'b1;
      send(8'hB4);
      check("R6 in_ready low while shifting", in_ready, 0);
      p0 = pulses;
      repeat (4) @(negedge clk);
      check("R6 cclk half rate", pulses - p0, 2);
      send(8'h3C);
      while (pulses < 16) @(negedge clk);
      check("R6 serial bits MSB first", cap, 16'hB43C);
      while (pulses < 19) @(negedge clk);
      check("R7 flush pulses after payload", cfg_ok, 0);
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      check("R7 cfg_ok", cfg_ok, 1);
      check("R12 cfg_err with ok", cfg_err, 0);

      // R10: pass-through vectors
      foreach (VEC[i]) begin
         @(negedge clk);
         in_data    = VEC[i][11:4];
         in_valid   = VEC[i][3];
         user_ready = VEC[i][2];
         #1;
         check("R10 user_valid", user_valid, VEC[i][1]);
         check("R10 in_ready", in_ready, VEC[i][0]);
         check("R10 user_data", user_data, VEC[i][11:4]);
      end
      in_valid = 1'b0;
      check("R12 cfg_ok held", cfg_ok, 1);

      // R2: enter strobe
      strobe(1'b1, 1'b0);
      check("R2 flags cleared", {cfg_ok, cfg_err}, 0);
      in_valid = 1'b1; #1;
      check("R2 user_valid blocked", user_valid, 0);
      check("R2 in_ready", in_ready, 1);
      in_valid = 1'b0;

      // R3: bad signature
      f0 = falls; p0 = pulses;
      send(8'hA5);
      send(8'h00);
      check("R3 cfg_err on mismatch", cfg_err, 1);
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'h77; #1;
      check("R3 drop accepts", in_ready, 1);
      check("R11 no leak in error", user_valid, 0);
      in_valid = 1'b0;
      send(8'hC3); send(8'h5A);
      repeat (20) @(negedge clk);
      check("R3 no prog pulse", falls - f0, 0);
      check("R3 no cclk", pulses - p0, 0);

      // R9: exit from error keeps flag
      strobe(1'b0, 1'b1);
      user_ready = 1'b1; in_valid = 1'b1; #1;
      check("R9 data mode after exit", user_valid, 1);
      check("R9 flag kept", cfg_err, 1);
      in_valid = 1'b0;

      // R5: init timeout
      strobe(1'b1, 1'b0);
      init_n = 1'b0;
      f0 = falls; p0 = pulses;
      header(32'd1);
      repeat (90) @(negedge clk);
      check("R5 init timeout err", cfg_err, 1);
      check("R5 no cclk", pulses - p0, 0);
      check("R4 single prog pulse", falls - f0, 1);

      // R8: done limit
      strobe(1'b1, 1'b0);
      init_n = 1'b1; done = 1'b0;
      p0 = pulses;
      header(32'd1);
      send(8'h81);
      while (pulses < p0 + 8) @(negedge clk);
      check("R6 single byte bits", cap[7:0], 8'h81);
      repeat (90) @(negedge clk);
      check("R8 total pulses", pulses - p0, 40);
      check("R8 cfg_err", cfg_err, 1);
      check("R8 cfg_ok", cfg_ok, 0);

      // R9: exit wins over enter
      strobe(1'b1, 1'b0);
      strobe(1'b1, 1'b1);
      in_valid = 1'b1; #1;
      check("R9 exit priority", user_valid, 1);
      in_valid = 1'b0;

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end

endmodule